// File: doc/BRIEF.md
# SIMD Floating-Point Magnitude Compare

This block compares packed single-precision floating-point lanes by magnitude. It takes two operand vectors, throws away each lane's sign, and tests whether the first magnitude is at least as large as the second, or strictly larger. Each lane of the result becomes a mask: every bit set when the test holds, every bit clear when it does not. The masks suit lane-wise select or blend logic further down the datapath.

A direction select exchanges the two operands before the test. This turns the greater-or-equal test into a less-or-equal test, and the greater-than test into a less-than test, without a second comparator. A width select chooses between a four-lane vector and a two-lane vector.

One register stage holds the mask. It is loaded on a valid input, and the result stays there until the next valid input.

Top module: `fp_abs_cmp`

## Requirements
- R1: Each operand lane is a 32-bit single-precision value. Lane i sits at bits [32i+31:32i]. Each result lane, when out_valid is high, is either 32'hFFFFFFFF (condition holds) or 32'h00000000 (condition fails).
- R2: Bit 31 of every operand lane is ignored. Flipping any operand sign bit never changes the result.
- R3: With `strict` = 0, a lane's result is all ones exactly when |first| >= |second|.
- R4: With `strict` = 1, a lane's result is all ones exactly when |first| > |second|. Equal magnitudes give all zeros.
- R5: With `swap` = 0, the first operand is `op_a` and the second is `op_b`. With `swap` = 1 they are exchanged, which gives the less-or-equal and less-than forms.
- R6: With `wide` = 1, all four lanes are compared. With `wide` = 0, only lanes 0 and 1 are compared. Result lanes 2 and 3 are then zero, and operand lanes 2 and 3 have no effect.
- R7: A lane is a NaN when its exponent is all ones and its fraction is nonzero. If either operand lane is a NaN, that result lane is all zeros under every select setting.
- R8: Positive and negative zero have equal magnitude. Subnormals, normals and infinities order by magnitude: a subnormal is greater than zero, and infinity is greater than the largest normal.
- R9: A result appears on `result` with `out_valid` high exactly one clock after `in_valid` is high. After a cycle with `in_valid` low, `out_valid` is low in the next cycle and `result` holds its previous value.
- R10: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_a | input | 128 | First operand vector, four 32-bit lanes |
| op_b | input | 128 | Second operand vector, four 32-bit lanes |
| wide | input | 1 | 1: four lanes; 0: two lanes |
| strict | input | 1 | 0: greater-or-equal; 1: greater-than |
| swap | input | 1 | 1: exchange operands before the test |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| result | output | 128 | Lane masks, all ones or all zeros per lane |

## Verification
The assertions assume that `in_valid`, the selects and the operands are stable around the sampling edge. They also assume that NaN inputs use the standard exponent-all-ones, nonzero-fraction pattern, so that detecting a NaN on an operand lane predicts a zero lane one cycle later. The stimulus changes inputs only on the falling clock edge. It holds every select constant within a transaction, and it places NaNs, signed zeros, subnormals and infinities in chosen lanes, so each expected mask follows from the requirements alone. In two-lane transactions the stimulus puts arbitrary data, NaNs included, in the upper operand lanes; the upper result lanes must still come out as zero.

// File: rtl/fpac_pkg.sv
package fpac_pkg;
   // Magnitude relation tested by the lane comparators.
   typedef enum logic {
      REL_GE = 1'b0,
      REL_GT = 1'b1
   } mag_rel_t;
endpackage

// File: rtl/fpac_lane.sv
module fpac_lane
   import fpac_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int EXP_W  = 8
) (
   input  logic [LANE_W-1:0] lhs,
   input  logic [LANE_W-1:0] rhs,
   input  mag_rel_t          rel,
   output logic              hit
);
   localparam int MAG_W  = LANE_W - 1;
   localparam int FRAC_W = MAG_W - EXP_W;

   logic [MAG_W-1:0] mag_l, mag_r;
   logic nan_l, nan_r, l_above, l_same;

   // Drop the sign; the remaining bits order as unsigned integers.
   assign mag_l = lhs[MAG_W-1:0];
   assign mag_r = rhs[MAG_W-1:0];

   assign nan_l = (&mag_l[MAG_W-1 -: EXP_W]) && (|mag_l[FRAC_W-1:0]);
   assign nan_r = (&mag_r[MAG_W-1 -: EXP_W]) && (|mag_r[FRAC_W-1:0]);

   assign l_above = mag_l > mag_r;
   assign l_same  = mag_l == mag_r;

   always_comb begin
      if (nan_l || nan_r)
         hit = 1'b0;
      else if (rel == REL_GT)
         hit = l_above;
      else
         hit = l_above || l_same;
   end
endmodule

// File: rtl/fpac_array.sv
module fpac_array
   import fpac_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   parameter int EXP_W  = 8
) (
   input  logic [LANES*LANE_W-1:0] vec_a,
   input  logic [LANES*LANE_W-1:0] vec_b,
   input  logic                    wide,
   input  logic                    strict,
   input  logic                    swap,
   output logic [LANES*LANE_W-1:0] mask
);
   localparam int HALF = LANES / 2;

   mag_rel_t rel;
   assign rel = strict ? REL_GT : REL_GE;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] first, second;
      logic hit, active;

      assign first  = swap ? vec_b[g*LANE_W +: LANE_W] : vec_a[g*LANE_W +: LANE_W];
      assign second = swap ? vec_a[g*LANE_W +: LANE_W] : vec_b[g*LANE_W +: LANE_W];

      if (g < HALF) begin : g_low
         assign active = 1'b1;
      end else begin : g_high
         assign active = wide;
      end

      fpac_lane #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_lane (
         .lhs(first),
         .rhs(second),
         .rel(rel),
         .hit(hit)
      );

      assign mask[g*LANE_W +: LANE_W] = {LANE_W{hit && active}};
   end
endmodule

// File: rtl/fp_abs_cmp.sv
module fp_abs_cmp #(
   parameter int LANES   = 4,
   parameter int LANE_W  = 32,
   parameter int EXP_W   = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int VEC_W  = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   input  logic             wide,
   input  logic             strict,
   input  logic             swap,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   localparam int MAG_W  = LANE_W - 1;
   localparam int FRAC_W = MAG_W - EXP_W;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("fp_abs_cmp: LANES must be even and at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_fields
      $error("fp_abs_cmp: LANE_W must leave at least one fraction bit");
   end

   logic [VEC_W-1:0] mask;

   fpac_array #(.LANES(LANES), .LANE_W(LANE_W), .EXP_W(EXP_W)) u_array (
      .vec_a (op_a),
      .vec_b (op_b),
      .wide  (wide),
      .strict(strict),
      .swap  (swap),
      .mask  (mask)
   );

   if (OUT_REG) begin : g_reg
      logic [VEC_W-1:0] res_q;
      logic             vld_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= in_valid;
            if (in_valid)
               res_q <= mask;
         end
      end

      assign result    = res_q;
      assign out_valid = vld_q;

      // R9
      lat_one_chk: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      // R9
      idle_low_chk: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> (!out_valid && $stable(result)));
      // R6
      narrow_top_chk: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !wide) |=> (result[VEC_W-1:VEC_W/2] == '0));

      for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
         logic a_nan, b_nan;
         assign a_nan = (&op_a[g*LANE_W+MAG_W-1 -: EXP_W]) && (|op_a[g*LANE_W +: FRAC_W]);
         assign b_nan = (&op_b[g*LANE_W+MAG_W-1 -: EXP_W]) && (|op_b[g*LANE_W +: FRAC_W]);
         // R7
         nan_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (a_nan || b_nan)) |=> (result[g*LANE_W +: LANE_W] == '0));
         // R1
         whole_lane_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (result[g*LANE_W +: LANE_W] == '0 ||
                           result[g*LANE_W +: LANE_W] == '1));
      end
   end else begin : g_comb
      assign result    = mask;
      assign out_valid = in_valid;
   end
endmodule

// File: tb/fp_abs_cmp_tb.sv
`timescale 1ns/1ps
module fp_abs_cmp_tb;
   localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000, N2 = 32'hC0000000;
   localparam logic [31:0] PH = 32'h3F000000, PZ = 32'h00000000, NZ = 32'h80000000;
   localparam logic [31:0] PI = 32'h7F800000, NI = 32'hFF800000, QN = 32'h7FC00000;
   localparam logic [31:0] SN = 32'h00000001, MX = 32'h7F7FFFFF, NN = 32'hFF800001;

   logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
   logic [127:0] op_a = '0, op_b = '0;
   logic wide = 1'b1, strict = 1'b0, swap = 1'b0;
   logic out_valid;
   logic [127:0] result;

   int n_cmp = 0, n_bad = 0;
   logic [127:0] exp_q[$];
   string        tag_q[$];
   logic [127:0] last_res = '0;
   bit           have_last = 1'b0;

   always #2.5 clk = ~clk;

   fp_abs_cmp u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .wide(wide), .strict(strict), .swap(swap),
      .out_valid(out_valid), .result(result)
   );

   function automatic bit is_nan(logic [31:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 0);
   endfunction

   function automatic logic [31:0] ref_lane(logic [31:0] x, logic [31:0] y, logic st);
      if (is_nan(x) || is_nan(y)) return 32'h0;
      if (st) return ({1'b0, x[30:0]} > {1'b0, y[30:0]}) ? 32'hFFFFFFFF : 32'h0;
      return ({1'b0, x[30:0]} >= {1'b0, y[30:0]}) ? 32'hFFFFFFFF : 32'h0;
   endfunction

   function automatic logic [127:0] ref_vec(logic [127:0] a, logic [127:0] b,
                                            logic w, logic st, logic sw);
      logic [127:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         if (w || i < 2)
            r[i*32 +: 32] = sw ? ref_lane(b[i*32 +: 32], a[i*32 +: 32], st)
                               : ref_lane(a[i*32 +: 32], b[i*32 +: 32], st);
      end
      return r;
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic send(logic [127:0] a, logic [127:0] b, logic w, logic st,
                       logic sw, string tag);
      @(negedge clk);
      op_a = a; op_b = b; wide = w; strict = st; swap = sw; in_valid = 1'b1;
      exp_q.push_back(ref_vec(a, b, w, st, sw));
      tag_q.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         op_a = {4{QN}}; op_b = {4{P1}};
      end
   endtask

   // Monitor: pops expected masks as results appear; checks hold when idle.
   initial begin
      forever begin
         @(negedge clk);
         if (rst) begin
            have_last = 1'b0;
         end else if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected out_valid", {127'b0, out_valid}, '0);
            end else begin
               check(tag_q.pop_front(), result, exp_q.pop_front());
               last_res  = result;
               have_last = 1'b1;
            end
         end else if (have_last) begin
            check("R9 hold while idle", result, last_res);
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset result", result, '0);
      check("R10 reset out_valid", {127'b0, out_valid}, '0);
      @(negedge clk);
      rst = 1'b0;

      // R3 basic greater-or-equal, four lanes
      send({P2, P1, PH, P1}, {P1, P2, P1, P1}, 1'b1, 1'b0, 1'b0, "R3 ge mixed");
      // R4 strict greater-than, equal lane drops
      send({P2, P1, PH, P1}, {P1, P2, P1, P1}, 1'b1, 1'b1, 1'b0, "R4 gt mixed");
      // R2 signs ignored
      send({N2, NZ, 32'hBF800000, N2}, {P1, P2, P1, 32'hC0000000}, 1'b1, 1'b0, 1'b0,
           "R2 sign ignored");
      send({N2, N2, N2, N2}, {P2, P2, P2, P2}, 1'b1, 1'b1, 1'b0, "R2 gt equal magnitudes");
      // R5 swapped operands: less-or-equal and less-than
      send({P2, P1, PH, P1}, {P1, P2, P1, P1}, 1'b1, 1'b0, 1'b1, "R5 le swap");
      send({P2, P1, PH, P1}, {P1, P2, P1, P1}, 1'b1, 1'b1, 1'b1, "R5 lt swap");
      // R8 zeros, subnormals, infinities
      send({PZ, SN, PI, MX}, {NZ, PZ, MX, PI}, 1'b1, 1'b0, 1'b0, "R8 ge zero/sub/inf");
      send({NZ, SN, NI, PI}, {PZ, NZ, PI, MX}, 1'b1, 1'b1, 1'b0, "R8 gt zero/sub/inf");
      // R7 NaN in either operand, all modes
      send({QN, P1, NN, P2}, {P1, QN, P1, QN}, 1'b1, 1'b0, 1'b0, "R7 nan ge");
      send({QN, P1, NN, P2}, {P1, QN, P1, QN}, 1'b1, 1'b1, 1'b1, "R7 nan lt");
      send({PI, QN, PI, PI}, {PI, PI, NN, NI}, 1'b1, 1'b0, 1'b1, "R7 nan vs inf");
      // R6 two-lane mode, junk upper lanes ignored
      send({P2, P2, P2, P1}, {PZ, PZ, P1, P1}, 1'b0, 1'b0, 1'b0, "R6 narrow ge");
      send({QN, PI, P1, P2}, {PZ, PZ, P2, P1}, 1'b0, 1'b1, 1'b1, "R6 narrow lt junk top");
      idle(3);
      // R1 all-ones / all-zeros lanes under back-to-back traffic
      for (int k = 0; k < 24; k++) begin
         logic [127:0] a, b;
         for (int j = 0; j < 4; j++) begin
            a[j*32 +: 32] = (32'h3F800000 + 32'(k * 977 + j * 40001)) ^ {k[0], 31'b0};
            b[j*32 +: 32] = (32'h3F800000 + 32'(j * 3331 + k * 12007)) ^ {j[0], 31'b0};
         end
         send(a, b, k[1], k[2], k[3], "R1 sweep");
      end
      idle(4);
      // R10 mid-run reset
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R10 reset after traffic result", result, '0);
      check("R10 reset after traffic out_valid", {127'b0, out_valid}, '0);
      rst = 1'b0;
      send({P1, P1, P1, P1}, {PH, PH, PH, PH}, 1'b1, 1'b0, 1'b0, "R9 after reset");
      idle(4);
      check("R9 queue drained", 128'(exp_q.size()), '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule